// File: doc/BRIEF.md
# Prescaled Dual Down-Counting Timer

This block holds two independent down-counting timers that share a single clock prescaler. The prescaler counts down once per system clock and, each time it passes zero, restarts from its own reload value and issues a one-cycle tick. Each timer steps down by one on every tick while its enable bit is set. When it underflows from zero it pulses its own interrupt line for one clock. Depending on its reload bit it then either restarts from its reload register or stops at zero and disables itself.

Software reaches every register through a simple 32-bit word bus with a write strobe and a combinational read path. Each timer has a counter, a reload value and a control word. Writing the control word with its load bit set copies the reload value into the counter at once. The block is used as a periodic tick source with the reload bit on, or as a one-shot delay with it off.

Top module: `prescaled_dual_timer`

## Requirements
- R1: After reset every register reads 0, both timers are disabled and both interrupt lines are low.
- R2: The prescaler counter (byte address 0x20, 10 bits) decrements once per clock. In a cycle where it is 0, it reloads from the prescaler reload register (0x24, 10 bits) and emits a tick, so a tick occurs every reload+1 clocks. A bus write to 0x20 sets the counter directly.
- R3: A timer whose control bit 0 (enable) is 1 decrements its counter by one on each prescaler tick.
- R4: While control bit 0 is 0 the timer counter holds its value whatever the prescaler does.
- R5: When an enabled timer is at 0 on a tick it underflows, and its interrupt output is 1 for exactly the following cycle. The timer at 0x00–0x08 drives irq[0] and the timer at 0x10–0x18 drives irq[1]; neither affects the other's line.
- R6: With control bit 1 (reload) at 1, an underflow copies the reload register into the counter and counting continues, so with prescaler reload S and timer reload L the interrupt period is (S+1)*(L+1) clocks.
- R7: With control bit 1 at 0, an underflow clears the enable bit and the counter stays at 0 with no further interrupts until software writes the timer again.
- R8: Writing control with bit 2 (load) at 1 copies the reload register into the counter in that same clock and takes priority over a decrement. The control word reads back as bit 1 = reload and bit 0 = enable, with bit 2 and all upper bits reading 0.
- R9: The register layout is counter/reload/control at 0x00/0x04/0x08 for timer 0 and at 0x10/0x14/0x18 for timer 1. Counters and reload registers are 24 bits wide, and wider write data is truncated, with the upper read bits returning 0.
- R10: A bus write to a timer counter address sets the counter to the written value and takes priority over a decrement in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 2 | One-cycle underflow pulses, bit 0 for timer 0, bit 1 for timer 1 |

## Verification
The hardest situations to reach are those where the prescaler phase, the timer count and a software write meet in the same clock. These are a control write landing on a decrement edge, a load racing a tick, and a one-shot underflow. The stimulus forces the prescaler to tick every clock by writing both its reload and its counter to zero. This makes every edge a decrement edge, so the bench can place a write exactly on one and predict the counter value. Random prescaler and timer reload pairs then run both timers in periodic mode, and the measured gaps between interrupts are compared with the period formula.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word offsets inside one timer's 4-word window
  localparam int OFS_CNT = 0;
  localparam int OFS_RL  = 1;
  localparam int OFS_CTL = 2;
  localparam int TMR_STRIDE = 4;

  // control bit positions
  localparam int CTL_EN  = 0;
  localparam int CTL_RLD = 1;
  localparam int CTL_LD  = 2;

  typedef struct packed {
    logic rld;
    logic en;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_we,
  input  logic          rl_we,
  input  logic [SW-1:0] wval,
  output logic [SW-1:0] sc_cnt,
  output logic [SW-1:0] sc_rl,
  output logic          tick
);
  function automatic logic [SW-1:0] sc_next(input logic [SW-1:0] cur,
                                            input logic [SW-1:0] rl);
    return (cur == '0) ? rl : SW'(cur - 1);
  endfunction

  assign tick = (sc_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_cnt <= '0;
      sc_rl  <= '0;
    end else begin
      if (rl_we) sc_rl <= wval;
      if (cnt_we) sc_cnt <= wval;
      else        sc_cnt <= sc_next(sc_cnt, sc_rl);
    end
  end

  // R2: wrap to reload value after a tick
  p_scaler_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we) |=> (sc_cnt == $past(sc_rl)));
  // R2: one step down per clock otherwise
  p_scaler_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> (sc_cnt == SW'($past(sc_cnt) - 1)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_we,
  input  logic          rl_we,
  input  logic          ctl_we,
  input  logic [CW-1:0] wval,
  input  logic [2:0]    wctl,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rl,
  output tmr_ctl_t      ctl,
  output logic          irq
);
  // named internal events
  logic ld;
  logic step;
  logic uf;

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] rval,
                                             input logic          rld);
    if (cur != '0) return CW'(cur - 1);
    return rld ? rval : '0;
  endfunction

  assign ld   = ctl_we & wctl[CTL_LD];
  assign step = tick & ctl.en & ~cnt_we & ~ld;
  assign uf   = step & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rl  <= '0;
      ctl <= '0;
      irq <= 1'b0;
    end else begin
      if (rl_we) rl <= wval;
      if (cnt_we)    cnt <= wval;
      else if (ld)   cnt <= rl;
      else if (step) cnt <= cnt_next(cnt, rl, ctl.rld);
      if (ctl_we) begin
        ctl.en  <= wctl[CTL_EN];
        ctl.rld <= wctl[CTL_RLD];
      end else if (uf && !ctl.rld) begin
        ctl.en <= 1'b0;
      end
      irq <= uf;
    end
  end

  // R3: one step down per tick while enabled
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0) |=> (cnt == CW'($past(cnt) - 1)));
  // R4: disabled timer holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !cnt_we && !ld) |=> $stable(cnt));
  // R5: interrupt only after an enabled zero count
  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt == '0) && $past(ctl.en) && $past(tick)));
  // R6: periodic restart
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && ctl.rld) |=> (cnt == $past(rl)));
  // R7: one-shot stops and disables
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !ctl.rld && !ctl_we) |=> (!ctl.en && cnt == '0));
  // R8: load wins over decrement
  p_load_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(rl)));
endmodule

// File: rtl/prescaled_dual_timer.sv
module prescaled_dual_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CW      = 24,
  parameter int SW      = 10,
  parameter int AW      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam int WW       = AW - 2;
  localparam int SCL_WORD = NUM_TMR * TMR_STRIDE;

  logic [WW-1:0] word;
  logic          tick;
  logic [SW-1:0] sc_cnt;
  logic [SW-1:0] sc_rl;
  logic [CW-1:0] t_cnt [NUM_TMR];
  logic [CW-1:0] t_rl  [NUM_TMR];
  tmr_ctl_t      t_ctl [NUM_TMR];
  logic          unused_bits;

  assign word        = addr[AW-1:2];
  assign unused_bits = ^{addr[1:0], wdata};

  tmr_prescaler #(.SW(SW)) u_scaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_we (wr_en && word == WW'(SCL_WORD)),
    .rl_we  (wr_en && word == WW'(SCL_WORD + 1)),
    .wval   (wdata[SW-1:0]),
    .sc_cnt (sc_cnt),
    .sc_rl  (sc_rl),
    .tick   (tick)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tmr_channel #(.CW(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt_we (wr_en && word == WW'(g*TMR_STRIDE + OFS_CNT)),
      .rl_we  (wr_en && word == WW'(g*TMR_STRIDE + OFS_RL)),
      .ctl_we (wr_en && word == WW'(g*TMR_STRIDE + OFS_CTL)),
      .wval   (wdata[CW-1:0]),
      .wctl   (wdata[2:0]),
      .cnt    (t_cnt[g]),
      .rl     (t_rl[g]),
      .ctl    (t_ctl[g]),
      .irq    (irq[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (word == WW'(i*TMR_STRIDE + OFS_CNT)) rdata = 32'(t_cnt[i]);
      if (word == WW'(i*TMR_STRIDE + OFS_RL))  rdata = 32'(t_rl[i]);
      if (word == WW'(i*TMR_STRIDE + OFS_CTL)) rdata = 32'(t_ctl[i]);
    end
    if (word == WW'(SCL_WORD))     rdata = 32'(sc_cnt);
    if (word == WW'(SCL_WORD + 1)) rdata = 32'(sc_rl);
  end

  // R5: a single timer never fires twice in a row unless its period is one clock
  p_irq_sep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !tick) |=> !irq[0]);
endmodule

// File: tb/test_prescaled_dual_timer.sv
`timescale 1ns/1ps
module test_prescaled_dual_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  prescaled_dual_timer i_prescaled_dual_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  localparam logic [5:0] A_SCC = 6'h20;
  localparam logic [5:0] A_SCR = 6'h24;

  function automatic logic [5:0] a_cnt(int t); return 6'(t*16);     endfunction
  function automatic logic [5:0] a_rl(int t);  return 6'(t*16 + 4); endfunction
  function automatic logic [5:0] a_ctl(int t); return 6'(t*16 + 8); endfunction
  function automatic int exp_period(int s, int l); return (s + 1) * (l + 1); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic fast_ticks();
    bus_wr(A_SCR, 0);
    bus_wr(A_SCC, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hits, pos, gap1, gap2, s, l, t, tries;
    v = $urandom(32'd41);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step();

    // R1 reset state
    foreach (v[i]) if (i < 2) begin
      rd(a_cnt(i), v); check("R1 cnt", v, 0);
      rd(a_rl(i), v);  check("R1 rl", v, 0);
      rd(a_ctl(i), v); check("R1 ctl", v, 0);
    end
    rd(A_SCC, v); check("R1 scaler", v, 0);
    rd(A_SCR, v); check("R1 scaler reload", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 prescaler sequence
    bus_wr(A_SCR, 5);
    bus_wr(A_SCC, 3);
    rd(A_SCC, v); check("R2 scaler write", v, 3);
    step(); rd(A_SCC, v); check("R2 dec", v, 2);
    step(); rd(A_SCC, v); check("R2 dec", v, 1);
    step(); rd(A_SCC, v); check("R2 dec", v, 0);
    step(); rd(A_SCC, v); check("R2 wrap", v, 5);
    step(); rd(A_SCC, v); check("R2 after wrap", v, 4);
    bus_wr(A_SCR, 32'hFFFF);
    rd(A_SCR, v); check("R2 scaler width", v, 32'h3FF);
    fast_ticks();

    // R9 / R10 counter write width and layout
    bus_wr(a_cnt(0), 32'hFF123456);
    rd(a_cnt(0), v); check("R9 cnt0 width", v, 32'h123456);
    bus_wr(a_rl(1), 32'hABCDEF01);
    rd(a_rl(1), v); check("R9 rl1 width", v, 32'hCDEF01);
    bus_wr(a_cnt(1), 77);
    rd(a_cnt(1), v); check("R10 cnt1 write", v, 77);
    rd(a_cnt(0), v); check("R9 cnt0 untouched", v, 32'h123456);

    // R4 hold while disabled, then R3 count
    bus_wr(a_cnt(0), 100);
    repeat (10) step();
    rd(a_cnt(0), v); check("R4 hold", v, 100);
    bus_wr(a_ctl(0), 1);
    rd(a_cnt(0), v); check("R3 enable edge", v, 100);
    repeat (10) step();
    rd(a_cnt(0), v); check("R3 count", v, 90);
    bus_wr(a_cnt(0), 500);
    rd(a_cnt(0), v); check("R10 write beats decrement", v, 500);
    bus_wr(a_ctl(0), 0);
    rd(a_cnt(0), v); check("R4 disable edge", v, 499);
    repeat (5) step();
    rd(a_cnt(0), v); check("R4 held", v, 499);

    // R8 load priority and control readback
    bus_wr(a_ctl(0), 1);
    bus_wr(a_rl(0), 50);
    bus_wr(a_ctl(0), 7);
    rd(a_cnt(0), v); check("R8 load", v, 50);
    rd(a_ctl(0), v); check("R8 ctl readback", v, 3);
    repeat (3) step();
    rd(a_cnt(0), v); check("R3 after load", v, 47);

    // R7 one-shot, R5 single pulse
    bus_wr(a_rl(0), 3);
    bus_wr(a_ctl(0), 5);
    hits = 0; pos = 0;
    for (int j = 1; j <= 20; j++) begin
      step();
      if (irq[0]) begin hits++; pos = j; end
      if (irq[1]) check("R5 irq1 quiet", 32'(irq[1]), 0);
    end
    check("R5 one pulse", hits, 1);
    check("R5 pulse cycle", pos, 4);
    rd(a_cnt(0), v); check("R7 stays zero", v, 0);
    rd(a_ctl(0), v); check("R7 enable cleared", v, 0);

    // R6 random periodic trials on both timers
    for (int k = 0; k < 8; k++) begin
      t = k % 2;
      s = $urandom % 4;
      l = 1 + $urandom % 6;
      bus_wr(a_ctl(1 - t), 0);
      bus_wr(A_SCR, 32'(s));
      bus_wr(a_rl(t), 32'(l));
      bus_wr(a_ctl(t), 7);
      tries = 0;
      while (!irq[t] && tries < 1000) begin step(); tries++; end
      gap1 = 0;
      do begin
        step(); gap1++;
        if (gap1 == 1) check("R5 pulse width", 32'(irq[t]), 0);
        if (irq[1-t]) check("R5 other line", 32'(irq[1-t]), 0);
      end while (!irq[t] && gap1 < 1000);
      gap2 = 0;
      do begin step(); gap2++; end while (!irq[t] && gap2 < 1000);
      check($sformatf("R6 period t%0d s%0d l%0d", t, s, l), gap1, exp_period(s, l));
      check("R6 period repeat", gap2, exp_period(s, l));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule